// File: doc/BRIEF.md
# Multi-Channel Double-Edge PWM Timer

A prescaled free-running timer with seven compare registers and six pulse-width outputs. A programmable prescaler divides the clock. The counter advances once per prescaler wrap. On a match, each compare register can flag an interrupt, zero the counter or halt it. When the PWM mode bit is clear, the outputs stay low and the block acts as a plain match timer.

In PWM mode, compare register 0 sets the period that all outputs share. Each output channel works in one of two modes. A single-edge channel rises at the start of every period and falls on its own compare value. A double-edge channel takes its rising edge from the compare register below it and its falling edge from its own register. Such a channel can produce a positive-going pulse or a negative-going one. Software writes new compare values into shadow copies. A shadow copy reaches the active compare set only after software sets that register's release bit, and then only at the next period boundary. This means no partial or runt pulse can appear.

The block is programmed through a synchronous register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `pwm_timer_top`

## Requirements
- R1: With run (control bit 0) set and clear (control bit 1) low, the count rises by one every (prescale limit + 1) clocks. Otherwise it holds.
- R2: While control bit 1 is set, the count and prescaler stay at zero. Reset leaves all registers and outputs at zero.
- R3: A match i whose action has the reset bit set (bit 3i+1 of the action register) makes the next count zero instead of count+1.
- R4: A match whose action has the stop bit set (bit 3i+2) clears control bit 0, so the count holds.
- R5: A match whose action has the interrupt bit set (bit 3i) sets flag i. Flags stay set until a 1 is written to that bit at the flag address. `irq` is the OR of all flags.
- R6: Shadow writes (address 8+i) do not change the active value (address 16+i) until release bit i (address 4) is set and a period boundary occurs. At that boundary the release bits clear.
- R7: With PWM mode (control bit 2) set, a match on register 0 always resets the count. The period is therefore register 0 plus one counts.
- R8: A single-edge channel n (mode bit n-1 = 0) is high for counts 0 to value(n)-1. A value of 0 keeps it low, and a value above register 0 keeps it high.
- R9: A double-edge channel n (mode bit n-1 = 1) goes high when the count reaches register n-1 and low when it reaches register n. When both edges land on the same count, the low edge wins.
- R10: With control bit 2 clear, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address (0 control, 1 prescale limit, 2 count, 3 flags, 4 release, 5 mode, 6 actions, 8-14 shadow, 16-22 active) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pwm_out | output | 6 | Channel outputs; bit n-1 is channel n |
| irq | output | 1 | OR of the sticky match flags |

## Verification
In timer mode, the block is run with a prescale limit of 2 and reset, interrupt and stop actions. This separates prescaler pacing, match reset and halting. In PWM mode, one set of compare values drives, at the same time, a constant-low channel, a constant-high channel, an ordinary single-edge channel, a positive double-edge pulse and a negative double-edge pulse. The high-count over a 20-count window tells each shape apart. Later phases stage a compare value without releasing it, then release it, then force a tie on a double-edge pair. These phases show that updates wait for release and a period boundary, and that the low edge wins a tie.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int ADDR_W      = 5;
    localparam int A_CTRL      = 0;
    localparam int A_PRESC     = 1;
    localparam int A_COUNT     = 2;
    localparam int A_FLAGS     = 3;
    localparam int A_RELEASE   = 4;
    localparam int A_MODE      = 5;
    localparam int A_ACTION    = 6;
    localparam int SHADOW_BASE = 8;
    localparam int ACTIVE_BASE = 16;

    typedef struct packed {
        logic stop_on;
        logic reset_on;
        logic irq_on;
    } match_act_t;

    typedef struct packed {
        logic pwm_en;
        logic cnt_clr;
        logic cnt_en;
    } ctrl_t;

    // Next level of one channel on a counter step.
    function automatic logic edge_next(logic dbl, logic start, logic hit_set,
                                       logic hit_clr, logic cur);
        if (dbl)
            return hit_clr ? 1'b0 : (hit_set ? 1'b1 : cur);
        else if (start)
            return !hit_clr;
        else
            return hit_clr ? 1'b0 : cur;
    endfunction
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] pc_q;
    logic         wrap;

    assign wrap = (pc_q >= limit);
    assign tick = run && !clear && wrap;

    always_ff @(posedge clk) begin
        if (rst || clear)
            pc_q <= '0;
        else if (run)
            pc_q <= wrap ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank #(
    parameter int W = 32,
    parameter int N = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        shadow_we,
    input  logic [W-1:0]        wdata,
    input  logic [N-1:0]        rel_set,
    input  logic                boundary,
    input  logic [W-1:0]        count,
    input  logic [W-1:0]        next_count,
    output logic [N-1:0][W-1:0] shadow_q,
    output logic [N-1:0][W-1:0] active_q,
    output logic [N-1:0]        rel_q,
    output logic [N-1:0]        hit_now,
    output logic [N-1:0]        hit_next
);
    always_ff @(posedge clk) begin
        if (rst)
            rel_q <= '0;
        else
            rel_q <= (boundary ? '0 : rel_q) | rel_set;
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [W-1:0] eff;
        logic         take;

        assign take        = boundary && rel_q[i];
        assign eff         = take ? shadow_q[i] : active_q[i];
        assign hit_now[i]  = (count == active_q[i]);
        assign hit_next[i] = (next_count == eff);

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                if (shadow_we[i]) shadow_q[i] <= wdata;
                if (take)         active_q[i] <= shadow_q[i];
            end
        end
    end
endmodule

// File: rtl/pwmt_out_stage.sv
module pwmt_out_stage
    import pwmt_pkg::*;
#(
    parameter int NM = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          pwm_en,
    input  logic          start,
    input  logic [NM-2:0] dbl,
    input  logic [NM-1:0] hit_next,
    output logic [NM-2:0] pwm_out
);
    for (genvar c = 0; c < NM - 1; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || !pwm_en)
                pwm_out[c] <= 1'b0;
            else if (tick)
                pwm_out[c] <= edge_next(dbl[c], start, hit_next[c],
                                        hit_next[c+1], pwm_out[c]);
        end
    end
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwmt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CNT_W-1:0]      wdata,
    output logic [CNT_W-1:0]      rdata,
    output logic [NUM_MATCH-2:0]  pwm_out,
    output logic                  irq
);
    localparam int NO = NUM_MATCH - 1;

    ctrl_t                           ctrl_q;
    logic [CNT_W-1:0]                presc_q, tc_q, next_count;
    logic [NUM_MATCH-1:0]            flags_q, irq_mask, rst_mask, stop_mask;
    logic [NO-1:0]                   mode_q;
    match_act_t [NUM_MATCH-1:0]      act_q;
    logic [NUM_MATCH-1:0]            shadow_we, rel_set, rel_q, hit_now, hit_next, match_evt;
    logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q, active_q;
    logic                            tick, any_reset, boundary, stop_evt;

    function automatic logic wr_at(int a);
        return wr_en && (addr == ADDR_W'(a));
    endfunction

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_dec
        assign shadow_we[i] = wr_at(SHADOW_BASE + i);
        assign irq_mask[i]  = act_q[i].irq_on;
        assign rst_mask[i]  = act_q[i].reset_on;
        assign stop_mask[i] = act_q[i].stop_on;
    end
    assign rel_set = wr_at(A_RELEASE) ? wdata[NUM_MATCH-1:0] : '0;

    pwmt_prescaler #(.W(CNT_W)) presc_i (
        .clk(clk), .rst(rst), .run(ctrl_q.cnt_en), .clear(ctrl_q.cnt_clr),
        .limit(presc_q), .tick(tick)
    );

    assign match_evt  = hit_now & {NUM_MATCH{tick}};
    assign any_reset  = (|(match_evt & rst_mask)) || (ctrl_q.pwm_en && match_evt[0]);
    assign boundary   = match_evt[0] && (ctrl_q.pwm_en || rst_mask[0]);
    assign stop_evt   = |(match_evt & stop_mask);
    assign next_count = any_reset ? '0 : tc_q + 1'b1;

    pwmt_match_bank #(.W(CNT_W), .N(NUM_MATCH)) bank_i (
        .clk(clk), .rst(rst), .shadow_we(shadow_we), .wdata(wdata),
        .rel_set(rel_set), .boundary(boundary), .count(tc_q),
        .next_count(next_count), .shadow_q(shadow_q), .active_q(active_q),
        .rel_q(rel_q), .hit_now(hit_now), .hit_next(hit_next)
    );

    pwmt_out_stage #(.NM(NUM_MATCH)) outs_i (
        .clk(clk), .rst(rst), .tick(tick), .pwm_en(ctrl_q.pwm_en),
        .start(boundary), .dbl(mode_q), .hit_next(hit_next), .pwm_out(pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.cnt_clr)
            tc_q <= '0;
        else if (tick)
            tc_q <= next_count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            mode_q  <= '0;
            act_q   <= '0;
            flags_q <= '0;
        end else begin
            if (wr_at(A_CTRL))  ctrl_q  <= ctrl_t'(wdata[2:0]);
            if (stop_evt)       ctrl_q.cnt_en <= 1'b0;
            if (wr_at(A_PRESC)) presc_q <= wdata;
            if (wr_at(A_MODE))  mode_q  <= wdata[NO-1:0];
            if (wr_at(A_ACTION))
                for (int i = 0; i < NUM_MATCH; i++)
                    act_q[i] <= match_act_t'(wdata[3*i +: 3]);
            flags_q <= (flags_q & ~(wr_at(A_FLAGS) ? wdata[NUM_MATCH-1:0] : '0))
                     | (match_evt & irq_mask);
        end
    end

    assign irq = |flags_q;

    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_CTRL:    rdata = CNT_W'(ctrl_q);
            A_PRESC:   rdata = presc_q;
            A_COUNT:   rdata = tc_q;
            A_FLAGS:   rdata = CNT_W'(flags_q);
            A_RELEASE: rdata = CNT_W'(rel_q);
            A_MODE:    rdata = CNT_W'(mode_q);
            A_ACTION:  rdata = CNT_W'(act_q);
            default:   rdata = '0;
        endcase
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (addr == ADDR_W'(SHADOW_BASE + i)) rdata = shadow_q[i];
            if (addr == ADDR_W'(ACTIVE_BASE + i)) rdata = active_q[i];
        end
    end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NM    = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic                  tick,
    input logic                  any_reset,
    input logic                  boundary,
    input logic                  stop_evt,
    input logic                  pwm_en,
    input logic                  cnt_clr,
    input logic                  cnt_en,
    input logic [CNT_W-1:0]      tc,
    input logic [NM-1:0]         flags,
    input logic [NM-1:0]         rel,
    input logic [NM-1:0][CNT_W-1:0] active,
    input logic [NM-2:0]         dbl,
    input logic [NM-1:0]         hit_now,
    input logic [NM-1:0]         hit_next,
    input logic [NM-2:0]         pwm_out
);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_clr) |=> $stable(tc));
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_clr && !any_reset) |=> (tc == $past(tc) + CNT_W'(1)));
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (tc == '0));
    p_match_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && any_reset) |=> (tc == '0));
    p_stop_r4: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !cnt_en);
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_W'(A_FLAGS)) |=> ((flags & $past(flags)) == $past(flags)));
    p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(active));
    p_release_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (boundary && !(wr_en && addr == ADDR_W'(A_RELEASE))) |=> (rel == '0));
    p_period_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_en && hit_now[0]) |=> (tc == '0));
    p_off_low_r10: assert property (@(posedge clk) disable iff (rst)
        !pwm_en |=> (pwm_out == '0));

    for (genvar c = 0; c < NM - 1; c++) begin : g_tie
        p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
            (pwm_en && tick && dbl[c] && hit_next[c+1]) |=> !pwm_out[c]);
    end
endmodule

bind pwm_timer_top pwmt_checker #(.CNT_W(CNT_W), .NM(NUM_MATCH)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .tick(tick),
    .any_reset(any_reset), .boundary(boundary), .stop_evt(stop_evt),
    .pwm_en(ctrl_q.pwm_en), .cnt_clr(ctrl_q.cnt_clr), .cnt_en(ctrl_q.cnt_en),
    .tc(tc_q), .flags(flags_q), .rel(rel_q), .active(active_q), .dbl(mode_q),
    .hit_now(hit_now), .hit_next(hit_next), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_top_tb_top.sv
module pwm_timer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pwm_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_pr, m_pc, m_tc, m_nc;
    logic [2:0]  m_ctrl;
    logic [6:0]  m_flags, m_rel, m_hit, m_hn;
    logic [5:0]  m_mode, m_out;
    logic [2:0]  m_act [7];
    logic [31:0] m_sh [7];
    logic [31:0] m_ac [7];
    bit          m_tick, m_anyr, m_stp, m_bnd;

    always @(posedge clk) begin
        if (rst) begin
            m_pr = 0; m_pc = 0; m_tc = 0; m_ctrl = 0; m_flags = 0; m_rel = 0;
            m_mode = 0; m_out = 0;
            for (int i = 0; i < 7; i++) begin m_act[i] = 0; m_sh[i] = 0; m_ac[i] = 0; end
        end else begin
            m_tick = m_ctrl[0] && !m_ctrl[1] && (m_pc >= m_pr);
            m_anyr = 0; m_stp = 0;
            for (int i = 0; i < 7; i++) begin
                m_hit[i] = m_tick && (m_tc == m_ac[i]);
                if (m_hit[i] && m_act[i][1]) m_anyr = 1;
                if (m_hit[i] && m_act[i][2]) m_stp = 1;
            end
            if (m_ctrl[2] && m_hit[0]) m_anyr = 1;
            m_bnd = m_hit[0] && (m_ctrl[2] || m_act[0][1]);
            m_nc  = m_anyr ? 32'd0 : m_tc + 1;
            for (int i = 0; i < 7; i++)
                m_hn[i] = (m_nc == ((m_bnd && m_rel[i]) ? m_sh[i] : m_ac[i]));
            for (int c = 0; c < 6; c++) begin
                if (!m_ctrl[2]) m_out[c] = 0;
                else if (m_tick) begin
                    if (m_mode[c]) begin
                        if (m_hn[c+1]) m_out[c] = 0;
                        else if (m_hn[c]) m_out[c] = 1;
                    end else if (m_bnd) m_out[c] = !m_hn[c+1];
                    else if (m_hn[c+1]) m_out[c] = 0;
                end
            end
            if (m_ctrl[1]) m_pc = 0;
            else if (m_ctrl[0]) m_pc = (m_pc >= m_pr) ? 0 : m_pc + 1;
            if (m_ctrl[1]) m_tc = 0;
            else if (m_tick) m_tc = m_nc;
            if (wr_en && addr == 3) m_flags = m_flags & ~wdata[6:0];
            for (int i = 0; i < 7; i++) if (m_hit[i] && m_act[i][0]) m_flags[i] = 1;
            for (int i = 0; i < 7; i++) if (m_bnd && m_rel[i]) m_ac[i] = m_sh[i];
            m_rel = (m_bnd ? 7'd0 : m_rel) | ((wr_en && addr == 4) ? wdata[6:0] : 7'd0);
            if (wr_en) begin
                case (addr)
                    0: m_ctrl = wdata[2:0];
                    1: m_pr   = wdata;
                    5: m_mode = wdata[5:0];
                    6: for (int i = 0; i < 7; i++) m_act[i] = wdata[3*i +: 3];
                    default: if (addr >= 8 && addr <= 14) m_sh[addr-8] = wdata;
                endcase
            end
            if (m_stp) m_ctrl[0] = 0;
        end
    end

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v = 0;
        case (a)
            0: v = {29'd0, m_ctrl};
            1: v = m_pr;
            2: v = m_tc;
            3: v = {25'd0, m_flags};
            4: v = {25'd0, m_rel};
            5: v = {26'd0, m_mode};
            6: for (int i = 0; i < 7; i++) v[3*i +: 3] = m_act[i];
            default: begin
                if (a >= 8 && a <= 14)  v = m_sh[a-8];
                if (a >= 16 && a <= 22) v = m_ac[a-16];
            end
        endcase
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check(pwm_out == m_out, "R8 R9 R10", "pwm_out vs model", 32'(pwm_out), 32'(m_out));
            check(irq == (m_flags != 0), "R5", "irq vs model", 32'(irq), 32'(m_flags != 0));
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk); addr = 5'(a); #1; v = rdata;
    endtask

    task automatic rd_model(int a, string req);
        logic [31:0] v;
        rd(a, v);
        check(v == m_read(a), req, $sformatf("read addr %0d", a), v, m_read(a));
    endtask

    task automatic rd_exp(int a, logic [31:0] e, string req);
        logic [31:0] v;
        rd(a, v);
        check(v == e, req, $sformatf("read addr %0d", a), v, e);
    endtask

    task automatic high_cnt(int idx, int n, int exp, string req);
        int c = 0;
        repeat (n) begin @(negedge clk); #1; if (pwm_out[idx]) c++; end
        check(c == exp, req, $sformatf("high counts ch%0d", idx + 1), 32'(c), 32'(exp));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // Reset state (R2, R10)
        rd_exp(0, 0, "R2");
        rd_exp(2, 0, "R2");
        check(pwm_out == 0, "R10", "pwm_out after reset", 32'(pwm_out), 0);

        // Timer mode: prescale 2, match0 reset+irq at 5, match1 irq at 3 (R1 R3 R5)
        wr(1, 2);
        wr(8, 5);
        wr(9, 3);
        wr(6, 32'h0B);
        wr(4, 32'h03);
        wr(0, 32'h1);
        idle(40);
        rd_model(2, "R1");
        ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            rd(2, v);
            if (v > 5) ok = 1'b0;
            idle(2);
        end
        check(ok, "R3", "count stays within 0..5", 32'(ok), 1);
        rd(3, v);
        check(v[1:0] == 2'b11, "R5", "flags 0 and 1 set", v, 3);
        check(irq == 1'b1, "R5", "irq high", 32'(irq), 1);
        wr(3, 32'h02);
        rd_model(3, "R5");
        idle(20);
        rd_model(3, "R5");

        // Stop action on match2 at 4 (R4)
        wr(10, 4);
        wr(4, 32'h04);
        idle(30);
        rd_exp(18, 4, "R6");
        wr(6, 32'h10B);
        idle(40);
        rd_exp(2, 5, "R4");
        rd_exp(0, 0, "R4");
        idle(5);
        rd_exp(2, 5, "R1");

        // Clear bit holds zero (R2)
        wr(0, 32'h3);
        idle(6);
        rd_exp(2, 0, "R2");
        rd_exp(0, 3, "R2");
        wr(0, 32'h0);
        wr(3, 32'h7F);
        rd_exp(3, 0, "R5");

        // PWM mode (R7 R8 R9)
        wr(6, 0);
        wr(1, 0);
        wr(8, 9);  wr(9, 0);  wr(10, 4); wr(11, 7);
        wr(12, 20); wr(13, 8); wr(14, 2);
        wr(5, 32'h24);
        wr(4, 32'h7F);
        wr(0, 32'h5);
        idle(30);
        ok = 1'b1;
        for (int k = 0; k < 15; k++) begin
            rd(2, v);
            if (v > 9) ok = 1'b0;
        end
        check(ok, "R7", "count within period 0..9", 32'(ok), 1);
        high_cnt(0, 20, 0,  "R8");
        high_cnt(1, 20, 8,  "R8");
        high_cnt(2, 20, 6,  "R9");
        high_cnt(3, 20, 20, "R8");
        high_cnt(4, 20, 16, "R8");
        high_cnt(5, 20, 8,  "R9");

        // Staged update needs release (R6)
        wr(10, 6);
        idle(25);
        rd_exp(18, 4, "R6");
        high_cnt(1, 20, 8, "R6");
        wr(4, 32'h04);
        rd_model(4, "R6");
        idle(25);
        rd_exp(18, 6, "R6");
        rd_exp(4, 0, "R6");
        high_cnt(1, 20, 12, "R6");

        // Tie on double-edge pair: clear wins (R9)
        wr(14, 8);
        wr(4, 32'h40);
        idle(25);
        high_cnt(5, 20, 0, "R9");

        // PWM off (R10)
        wr(0, 32'h1);
        idle(2);
        ok = 1'b1;
        repeat (10) begin @(negedge clk); #1; if (pwm_out != 0) ok = 1'b0; end
        check(ok, "R10", "outputs low with pwm off", 32'(ok), 1);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule